// File: doc/BRIEF.md
# Legacy ATA Port Access Filter

This block sits between a host I/O decoder and the task-file logic of a two-channel ATA controller. Each channel exposes two legacy windows. The data window is eight bytes wide and holds the data port and the task-file registers. The control window is four bytes wide, and only one byte in it has a register behind it. Every host access carries a window select, a byte offset, a size code and a channel number. The block checks whether that combination of offset and size reaches a real register.

A legal access is passed on in the same cycle as a strobe to the task-file side. The strobe carries a translated register address, the size, the write data and the unchanged channel number. An illegal access produces no strobe. If it is a read, it returns all ones across the access width. If it is a write, it is dropped.

One cycle after each request, a registered response appears. It carries a valid pulse, a reject flag and the read data. The read data then holds until the next read.

Top module: `ide_port_filter`

## Requirements
- R1: In the control window (`req_win`=1), a 1-byte access (`req_size`=0) at offset 2 is forwarded with `tf_ctrl`=1 and `tf_addr`=4. A read of it returns `tf_rdata[7:0]` with the upper 24 bits at zero.
- R2: Any other control-window access raises no `tf_valid` and sets `rsp_reject`. This includes a 1-byte access at offsets 0, 1, 3 to 7, and any 2- or 4-byte access. A read returns all ones of the access width: 0xFF, 0xFFFF or 0xFFFFFFFF for size codes 0, 1, 2.
- R3: In the data window (`req_win`=0), a 1-byte access at any offset 0 to 7 is forwarded with `tf_ctrl`=0, `tf_addr` equal to the offset and `tf_size`=0.
- R4: A 2-byte (size code 1) or 4-byte (size code 2) data-window access at offset 0 is forwarded with `tf_addr`=0 and the same size code. A read of it returns `tf_rdata` masked to 16 or 32 bits.
- R5: A 2- or 4-byte data-window access at a nonzero offset raises no `tf_valid` and sets `rsp_reject`. A read of it returns all ones of its width.
- R6: Size code 3 is reserved. It is rejected in both windows, and a read with it returns 0xFFFFFFFF.
- R7: `rsp_valid` is high exactly in the cycle after each request cycle and low otherwise. `rsp_reject` is high only together with `rsp_valid`.
- R8: `tf_write` and `tf_wdata` follow the request. A rejected write produces no strobe, so no register is touched.
- R9: `rsp_rdata` changes only after a read request. A write or an idle cycle leaves it unchanged.
- R10: `tf_chan` equals `req_chan` on every forwarded access.
- R11: After reset, `rsp_valid`, `rsp_reject` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | 0 = data window, 1 = control window |
| req_chan | input | CH_W | Channel number |
| req_off | input | OFF_W | Byte offset within the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| req_wdata | input | 32 | Write data |
| tf_valid | output | 1 | Forward strobe to the task-file side |
| tf_write | output | 1 | Direction of the forwarded access |
| tf_ctrl | output | 1 | Forwarded access targets the control space |
| tf_chan | output | CH_W | Channel of the forwarded access |
| tf_addr | output | OFF_W | Translated register address |
| tf_size | output | 2 | Size code of the forwarded access |
| tf_wdata | output | 32 | Forwarded write data |
| tf_rdata | input | 32 | Read data returned by the task-file side in the strobe cycle |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_reject | output | 1 | Access was illegal |
| rsp_rdata | output | 32 | Read result, held until the next read |

## Verification
The assertions assume that `tf_rdata` is valid in the same cycle as `tf_valid`. They also assume that every request input is settled before the clock edge that samples it. The bench therefore models the task-file side as a combinational function of the forwarded channel, space and address. It changes every request input only at the falling edge.

The properties place no limit on how requests follow one another. The bench still mixes back-to-back requests with idle gaps. It does this so that the hold behaviour of the read data and the single-cycle response pulse are both observed.

// File: rtl/ide_filt_pkg.sv
package ide_filt_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic {
    WIN_DATA = 1'b0,
    WIN_CTRL = 1'b1
  } win_e;

  localparam int unsigned BUS_W = 32;

  // Lane mask covering the bytes of one access; a reserved size spans the whole bus.
  function automatic logic [BUS_W-1:0] lane_mask(input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/ide_filt_decode.sv
module ide_filt_decode
  import ide_filt_pkg::*;
#(
  parameter int unsigned OFF_W        = 3,
  parameter int unsigned CTRL_OFF     = 2,
  parameter int unsigned CTRL_TF_ADDR = 4
) (
  input  logic             win,
  input  logic [OFF_W-1:0] off,
  input  logic [1:0]       size,
  output logic             legal,
  output logic [OFF_W-1:0] xaddr
);

  localparam logic [OFF_W-1:0] CTRL_OFF_V  = OFF_W'(CTRL_OFF);
  localparam logic [OFF_W-1:0] CTRL_ADDR_V = OFF_W'(CTRL_TF_ADDR);

  // Legality depends on window, offset and size together.
  function automatic logic is_legal(input logic w, input logic [OFF_W-1:0] o,
                                    input logic [1:0] s);
    if (acc_size_e'(s) == SZ_RSVD)
      is_legal = 1'b0;
    else if (win_e'(w) == WIN_CTRL)
      is_legal = (o == CTRL_OFF_V) && (acc_size_e'(s) == SZ_BYTE);
    else
      is_legal = (acc_size_e'(s) == SZ_BYTE) || (o == '0);
  endfunction

  always_comb begin
    legal = is_legal(win, off, size);
    xaddr = (win_e'(win) == WIN_CTRL) ? CTRL_ADDR_V : off;
  end

endmodule

// File: rtl/ide_filt_rdfill.sv
module ide_filt_rdfill
  import ide_filt_pkg::*;
(
  input  logic             legal,
  input  logic [1:0]       size,
  input  logic [BUS_W-1:0] tf_rdata,
  output logic [BUS_W-1:0] rd_value
);

  logic [BUS_W-1:0] mask;

  always_comb begin
    mask     = lane_mask(size);
    rd_value = legal ? (tf_rdata & mask) : mask;
  end

endmodule

// File: rtl/ide_filt_resp.sv
module ide_filt_resp
  import ide_filt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             legal,
  input  logic [BUS_W-1:0] rd_value,
  output logic             rsp_valid,
  output logic             rsp_reject,
  output logic [BUS_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_reject <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_reject <= req_valid && !legal;
      if (req_valid && !req_write)
        rsp_rdata <= rd_value;
    end
  end

endmodule

// File: rtl/ide_port_filter.sv
module ide_port_filter
  import ide_filt_pkg::*;
#(
  parameter int unsigned CH_W         = 1,
  parameter int unsigned OFF_W        = 3,
  parameter int unsigned CTRL_OFF     = 2,
  parameter int unsigned CTRL_TF_ADDR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_win,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [OFF_W-1:0] req_off,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             tf_valid,
  output logic             tf_write,
  output logic             tf_ctrl,
  output logic [CH_W-1:0]  tf_chan,
  output logic [OFF_W-1:0] tf_addr,
  output logic [1:0]       tf_size,
  output logic [31:0]      tf_wdata,
  input  logic [31:0]      tf_rdata,
  output logic             rsp_valid,
  output logic             rsp_reject,
  output logic [31:0]      rsp_rdata
);

  logic             legal_w;
  logic [OFF_W-1:0] xaddr_w;
  logic [31:0]      rd_value_w;

  ide_filt_decode #(
    .OFF_W       (OFF_W),
    .CTRL_OFF    (CTRL_OFF),
    .CTRL_TF_ADDR(CTRL_TF_ADDR)
  ) u_decode (
    .win  (req_win),
    .off  (req_off),
    .size (req_size),
    .legal(legal_w),
    .xaddr(xaddr_w)
  );

  ide_filt_rdfill u_rdfill (
    .legal   (legal_w),
    .size    (req_size),
    .tf_rdata(tf_rdata),
    .rd_value(rd_value_w)
  );

  ide_filt_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .legal     (legal_w),
    .rd_value  (rd_value_w),
    .rsp_valid (rsp_valid),
    .rsp_reject(rsp_reject),
    .rsp_rdata (rsp_rdata)
  );

  always_comb begin
    tf_valid = req_valid && legal_w;
    tf_write = req_write;
    tf_ctrl  = req_win;
    tf_chan  = req_chan;
    tf_addr  = xaddr_w;
    tf_size  = req_size;
    tf_wdata = req_wdata;
  end

endmodule

// File: rtl/ide_port_filter_chk.sv
module ide_port_filter_chk #(
  parameter int unsigned CH_W  = 1,
  parameter int unsigned OFF_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_win,
  input logic [CH_W-1:0]  req_chan,
  input logic [OFF_W-1:0] req_off,
  input logic [1:0]       req_size,
  input logic             tf_valid,
  input logic             tf_ctrl,
  input logic [CH_W-1:0]  tf_chan,
  input logic [OFF_W-1:0] tf_addr,
  input logic [1:0]       tf_size,
  input logic             rsp_valid,
  input logic             rsp_reject,
  input logic [31:0]      rsp_rdata
);

  // R1: a forwarded control access is one byte wide at register address 4
  a_r1_ctrl_target: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_valid && tf_ctrl) |-> (tf_addr == OFF_W'(4) && tf_size == 2'd0));

  // R2: control accesses other than one byte at offset 2 are not forwarded
  a_r2_ctrl_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_win && !(req_off == OFF_W'(2) && req_size == 2'd0)) |-> !tf_valid);

  // R5: a wide data access away from offset 0 is not forwarded
  a_r5_wide_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_win && req_size != 2'd0 && req_off != '0) |-> !tf_valid);

  // R6: the reserved size is never forwarded
  a_r6_rsvd_block: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3) |-> !tf_valid);

  // R7: one response pulse per request, none otherwise
  a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r7_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r7_reject_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_reject |-> rsp_valid);
  a_r7_reject_when_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tf_valid) |=> rsp_reject);

  // R2: a dropped read fills at least the low byte with ones
  a_r2_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !tf_valid) |=> (rsp_rdata[7:0] == 8'hFF));

  // R9: read data only moves after a read request
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> $stable(rsp_rdata));

  // R10: channel passes through on forwarded accesses
  a_r10_chan: assert property (@(posedge clk) disable iff (!rst_n)
    tf_valid |-> (tf_chan == req_chan));

endmodule

bind ide_port_filter ide_port_filter_chk #(
  .CH_W (CH_W),
  .OFF_W(OFF_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_win   (req_win),
  .req_chan  (req_chan),
  .req_off   (req_off),
  .req_size  (req_size),
  .tf_valid  (tf_valid),
  .tf_ctrl   (tf_ctrl),
  .tf_chan   (tf_chan),
  .tf_addr   (tf_addr),
  .tf_size   (tf_size),
  .rsp_valid (rsp_valid),
  .rsp_reject(rsp_reject),
  .rsp_rdata (rsp_rdata)
);

// File: tb/ide_port_filter_tb.sv
module ide_port_filter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // {win, size[1:0], off[2:0], expect_forward}
  localparam logic [6:0] VEC [0:NVEC-1] = '{
    {1'b1, 2'd0, 3'd2, 1'b1},
    {1'b1, 2'd0, 3'd0, 1'b0},
    {1'b1, 2'd0, 3'd3, 1'b0},
    {1'b1, 2'd1, 3'd2, 1'b0},
    {1'b1, 2'd2, 3'd2, 1'b0},
    {1'b1, 2'd0, 3'd6, 1'b0},
    {1'b0, 2'd0, 3'd0, 1'b1},
    {1'b0, 2'd0, 3'd5, 1'b1},
    {1'b0, 2'd0, 3'd7, 1'b1},
    {1'b0, 2'd1, 3'd0, 1'b1},
    {1'b0, 2'd2, 3'd0, 1'b1},
    {1'b0, 2'd1, 3'd2, 1'b0},
    {1'b0, 2'd2, 3'd4, 1'b0},
    {1'b0, 2'd3, 3'd0, 1'b0},
    {1'b1, 2'd3, 3'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [0:0]  req_chan = '0;
  logic [2:0]  req_off = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        tf_valid, tf_write, tf_ctrl;
  logic [0:0]  tf_chan;
  logic [2:0]  tf_addr;
  logic [1:0]  tf_size;
  logic [31:0] tf_wdata, tf_rdata;
  logic        rsp_valid, rsp_reject;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] last_rd = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Model of the task-file side: a pattern depending on channel, space and address.
  function automatic logic [31:0] rf_model(input logic ch, input logic ctl, input logic [2:0] a);
    return {8'hD4, 7'h4B, ch, 8'h1E, ch, ctl, 3'b000, a};
  endfunction

  function automatic logic [31:0] width_ones(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign tf_rdata = rf_model(tf_chan[0], tf_ctrl, tf_addr);

  ide_port_filter u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_win(req_win), .req_chan(req_chan), .req_off(req_off), .req_size(req_size),
    .req_wdata(req_wdata), .tf_valid(tf_valid), .tf_write(tf_write), .tf_ctrl(tf_ctrl),
    .tf_chan(tf_chan), .tf_addr(tf_addr), .tf_size(tf_size), .tf_wdata(tf_wdata),
    .tf_rdata(tf_rdata), .rsp_valid(rsp_valid), .rsp_reject(rsp_reject),
    .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic w, input logic [1:0] s, input logic fwd);
    if (s == 2'd3) return "R6";
    if (w) return fwd ? "R1" : "R2";
    if (s == 2'd0) return "R3";
    return fwd ? "R4" : "R5";
  endfunction

  // Drive one request at the falling edge, check the strobe, then the response.
  task automatic access(input logic wr, input logic w, input logic ch, input logic [2:0] o,
                        input logic [1:0] s, input logic fwd, input bit idle_after);
    string t;
    logic [31:0] exp_rd;
    t = tag_of(w, s, fwd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_win = w; req_chan = ch;
    req_off = o; req_size = s; req_wdata = 32'h1357_9BDF ^ {29'd0, o};
    #1;
    check({t, " strobe"}, {31'd0, tf_valid}, {31'd0, fwd});
    if (fwd) begin
      check({t, " addr"}, {29'd0, tf_addr}, w ? 32'd4 : {29'd0, o});
      check({t, " space"}, {31'd0, tf_ctrl}, {31'd0, w});
      check({t, " size"}, {30'd0, tf_size}, {30'd0, s});
      check("R10 chan", {31'd0, tf_chan}, {31'd0, ch});
      check("R8 dir", {31'd0, tf_write}, {31'd0, wr});
      if (wr) check("R8 wdata", tf_wdata, req_wdata);
    end
    exp_rd = fwd ? (rf_model(ch, w, w ? 3'd4 : o) & width_ones(s)) : width_ones(s);
    @(posedge clk);
    #1;
    check("R7 valid", {31'd0, rsp_valid}, 32'd1);
    check({t, " reject"}, {31'd0, rsp_reject}, {31'd0, !fwd});
    if (!wr) begin
      check(fwd ? {t, " R8 rdata"} : {t, " fill"}, rsp_rdata, exp_rd);
      last_rd = exp_rd;
    end else begin
      check("R9 write hold", rsp_rdata, last_rd);
    end
    if (idle_after) begin
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R7 idle", {31'd0, rsp_valid}, 32'd0);
      check("R7 no reject", {31'd0, rsp_reject}, 32'd0);
      check("R9 idle hold", rsp_rdata, last_rd);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 reject", {31'd0, rsp_reject}, 32'd0);
    check("R11 rdata", rsp_rdata, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table walk: every vector as read and write, channel alternating, back to back.
    for (int rw = 0; rw < 2; rw++) begin
      for (int i = 0; i < NVEC; i++) begin
        access(rw[0], VEC[i][6], i[0] ^ rw[0], VEC[i][3:1], VEC[i][5:4], VEC[i][0], 1'b0);
      end
    end

    // R3: every data-window byte offset on channel 1, with idle gaps.
    for (int o = 0; o < 8; o++) begin
      access(1'b0, 1'b0, 1'b1, o[2:0], 2'd0, 1'b1, o == 7);
    end

    // R5 / R2: every nonzero offset for wide data reads; every other control byte offset.
    for (int o = 1; o < 8; o++) begin
      access(1'b0, 1'b0, 1'b0, o[2:0], 2'd2, 1'b0, 1'b0);
      if (o != 2) access(1'b0, 1'b1, 1'b1, o[2:0], 2'd0, 1'b0, 1'b0);
    end

    // R9: read, then rejected write, then idle: data must hold.
    access(1'b0, 1'b1, 1'b0, 3'd2, 2'd0, 1'b1, 1'b0);
    access(1'b1, 1'b0, 1'b0, 3'd3, 2'd1, 1'b0, 1'b1);

    // R11: reset in mid-traffic clears the response.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R11 mid valid", {31'd0, rsp_valid}, 32'd0);
    check("R11 mid rdata", rsp_rdata, 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    last_rd = '0;
    access(1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b1, 1'b1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule